// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block takes an LCD panel through its supply and backlight phases in a fixed order. Software programs the timing through a small write-only register window. The block then drives two enables: one for the panel supply rail and one for the backlight. It also reports the current phase of the sequence on status outputs.

All delays are counted in ticks. A programmable prescaler derives the tick from the clock, so one tick can be set to 100 microseconds. The minimum off time between power cycles uses a coarser unit of `CYC_UNIT` ticks, nominally 100 ms. Writes to the timing registers are accepted only while the control register holds an unlock key. A chip-level warm reset can optionally force the panel down.

Top module: `pps_sequencer`

## Requirements
- R1: After `rst_n` is released, `panel_supply_en`, `backlight_en`, `stat_on` and `stat_busy` are 0, `stat_phase` is 0, and all registers read as zero.
- R2: The power-up order is as follows.
  - A set request bit (control address 0, bit 0) raises `panel_supply_en` first.
  - After the power-up delay (address 1 bits [12:0]) and then the backlight-on delay (address 1 bits [28:16]), `backlight_en` rises.
  - `stat_on` rises in the same cycle as `backlight_en`.
- R3: The power-down order is as follows.
  - Clearing the request lowers `backlight_en` first.
  - After the backlight-off delay (address 2 bits [28:16]), `panel_supply_en` falls.
  - After the power-down delay (address 2 bits [12:0]), `stat_on` falls.
- R4: One tick lasts divider+1 clock cycles, where the divider is address 3 bits [15:0]. Every delay field counts ticks.
- R5: The power-cycle field (address 3 bits [20:16]) sets a minimum wait between the fall of `stat_on` and the next rise of `panel_supply_en`. The wait is at least field × `CYC_UNIT` ticks. The value written already includes the extra safety unit.
- R6: The lock works as follows.
  - Writes to addresses 1 to 3 take effect only while the control key field (address 0 bits [31:16]) holds `UNLOCK_KEY` (default 16'hA5C3).
  - A write to the control register always takes effect.
- R7: If the power-up, backlight-on, power-down and backlight-off fields are all zero, the block uses 400, 2000, 350 and 2000 ticks in their place.
- R8: Clearing the request before the backlight is on abandons the power-up. `panel_supply_en` falls without `backlight_en` ever rising, the power-down delay is observed, and `stat_on` stays 0.
- R9: The warm reset works as follows.
  - A pulse on `warm_rst` clears the request, and so starts power-down, when control bit 1 is set.
  - When control bit 1 is clear, the pulse has no effect.
- R10: The encoding of `stat_phase` is:
  - 0 for off;
  - 1 for powering up, including the power-cycle wait;
  - 2 for on;
  - 3 for powering down.
  `stat_busy` is 1 exactly in phases 1 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 on-delays, 2 off-delays, 3 divisor |
| wr_data | input | 32 | Write data |
| warm_rst | input | 1 | Chip warm-reset event (does not clear registers) |
| panel_supply_en | output | 1 | Panel supply rail enable |
| backlight_en | output | 1 | Backlight enable |
| stat_on | output | 1 | Panel fully powered |
| stat_busy | output | 1 | Sequence in progress |
| stat_phase | output | 2 | Current phase |

## Verification
The assertions assume the following about the inputs:
- `wr_addr` and `wr_data` are meaningful only while `wr_en` is high.
- The divider is changed only while the panel is off. A lowered divider during a count would stretch a single tick by a wrap of the prescaler.

The stimulus writes every timing register before it raises the request, and only when `stat_phase` is 0. It uses a small divider so that the default delays and the power-cycle wait fit in a short run. Each timing check uses a window one tick wide, because the prescaler runs freely and is not restarted at each phase.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_CYC, ST_PU_SUP, ST_PU_BL, ST_ON, ST_PD_BL, ST_PD_SUP
  } pps_state_e;

  localparam logic [1:0] PH_OFF  = 2'd0;
  localparam logic [1:0] PH_UP   = 2'd1;
  localparam logic [1:0] PH_ON   = 2'd2;
  localparam logic [1:0] PH_DOWN = 2'd3;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_ON   = 2'd1;
  localparam logic [1:0] A_OFF  = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;
endpackage

// File: rtl/pps_regs.sv
module pps_regs
  import pps_pkg::*;
#(
  parameter int DLY_W = 13,
  parameter int DIV_W = 16,
  parameter int CYC_W = 5,
  parameter logic [15:0] UNLOCK_KEY = 16'hA5C3,
  parameter int DEF_PU = 400,
  parameter int DEF_BON = 2000,
  parameter int DEF_PD = 350,
  parameter int DEF_BOFF = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             warm_rst,
  output logic             req,
  output logic [DLY_W-1:0] pu_dly,
  output logic [DLY_W-1:0] bon_dly,
  output logic [DLY_W-1:0] pd_dly,
  output logic [DLY_W-1:0] boff_dly,
  output logic [DIV_W-1:0] divider,
  output logic [CYC_W-1:0] cyc_field
);
  logic             req_q, pdr_q;
  logic [15:0]      key_q;
  logic [DLY_W-1:0] pu_q, bon_q, pd_q, boff_q;
  logic [DIV_W-1:0] div_q;
  logic [CYC_W-1:0] cyc_q;
  logic             unlocked, ctrl_we, on_we, off_we, div_we, all_zero;

  assign unlocked = (key_q == UNLOCK_KEY);
  assign ctrl_we  = wr_en && (wr_addr == A_CTRL);
  assign on_we    = wr_en && (wr_addr == A_ON)  && unlocked;
  assign off_we   = wr_en && (wr_addr == A_OFF) && unlocked;
  assign div_we   = wr_en && (wr_addr == A_DIV) && unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      pdr_q <= 1'b0;
      key_q <= '0;
    end else if (ctrl_we) begin
      req_q <= wr_data[0];
      pdr_q <= wr_data[1];
      key_q <= wr_data[31:16];
    end else if (warm_rst && pdr_q) begin
      req_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pu_q <= '0; bon_q <= '0;
    end else if (on_we) begin
      pu_q  <= wr_data[DLY_W-1:0];
      bon_q <= wr_data[16 +: DLY_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q <= '0; boff_q <= '0;
    end else if (off_we) begin
      pd_q   <= wr_data[DLY_W-1:0];
      boff_q <= wr_data[16 +: DLY_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; cyc_q <= '0;
    end else if (div_we) begin
      div_q <= wr_data[DIV_W-1:0];
      cyc_q <= wr_data[16 +: CYC_W];
    end
  end

  assign all_zero  = (pu_q == '0) && (bon_q == '0) && (pd_q == '0) && (boff_q == '0);
  assign pu_dly    = all_zero ? DLY_W'(DEF_PU)   : pu_q;
  assign bon_dly   = all_zero ? DLY_W'(DEF_BON)  : bon_q;
  assign pd_dly    = all_zero ? DLY_W'(DEF_PD)   : pd_q;
  assign boff_dly  = all_zero ? DLY_W'(DEF_BOFF) : boff_q;
  assign req       = req_q;
  assign divider   = div_q;
  assign cyc_field = cyc_q;

  AST_LOCKED_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(div_q) && $stable(cyc_q)); // R6
  AST_LOCKED_DLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(pu_q) && $stable(pd_q)); // R6
  AST_WARM_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_rst && pdr_q && !ctrl_we) |=> !req_q); // R9
endmodule

// File: rtl/pps_tick.sv
module pps_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divider,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick  = (cnt_q == divider);
  assign cnt_d = tick ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
  import pps_pkg::*;
#(
  parameter int DLY_W = 13,
  parameter int CYC_W = 5,
  parameter int CYC_UNIT = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             req,
  input  logic [DLY_W-1:0] pu_dly,
  input  logic [DLY_W-1:0] bon_dly,
  input  logic [DLY_W-1:0] pd_dly,
  input  logic [DLY_W-1:0] boff_dly,
  input  logic [CYC_W-1:0] cyc_field,
  output logic             supply_en,
  output logic             bl_en,
  output logic             on,
  output logic             busy,
  output logic [1:0]       phase
);
  localparam int CC_W = $clog2(((1 << CYC_W) - 1) * CYC_UNIT + 1);

  pps_state_e       state_q, state_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic [CC_W-1:0]  cyc_q, cyc_d;
  logic             on_q, on_d, cyc_load, cnt_done;

  assign cnt_done = (cnt_q == '0);

  always_comb begin
    state_d  = state_q;
    cnt_d    = (tick && !cnt_done) ? cnt_q - 1'b1 : cnt_q;
    on_d     = on_q;
    cyc_load = 1'b0;
    unique case (state_q)
      ST_OFF:    if (req) state_d = ST_CYC;
      ST_CYC:
        if (!req) state_d = ST_OFF;
        else if (cyc_q == '0) begin state_d = ST_PU_SUP; cnt_d = pu_dly; end
      ST_PU_SUP:
        if (!req) begin state_d = ST_PD_SUP; cnt_d = pd_dly; end
        else if (cnt_done) begin state_d = ST_PU_BL; cnt_d = bon_dly; end
      ST_PU_BL:
        if (!req) begin state_d = ST_PD_SUP; cnt_d = pd_dly; end
        else if (cnt_done) begin state_d = ST_ON; on_d = 1'b1; end
      ST_ON:
        if (!req) begin state_d = ST_PD_BL; cnt_d = boff_dly; end
      ST_PD_BL:
        if (cnt_done) begin state_d = ST_PD_SUP; cnt_d = pd_dly; end
      ST_PD_SUP:
        if (cnt_done) begin state_d = ST_OFF; on_d = 1'b0; cyc_load = 1'b1; end
      default: state_d = ST_OFF;
    endcase
  end

  always_comb begin
    if (cyc_load)                 cyc_d = CC_W'(cyc_field) * CC_W'(CYC_UNIT);
    else if (tick && cyc_q != '0) cyc_d = cyc_q - 1'b1;
    else                          cyc_d = cyc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      cyc_q   <= '0;
      on_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cyc_q   <= cyc_d;
      on_q    <= on_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_OFF:                      phase = PH_OFF;
      ST_CYC, ST_PU_SUP, ST_PU_BL: phase = PH_UP;
      ST_ON:                       phase = PH_ON;
      default:                     phase = PH_DOWN;
    endcase
  end

  assign supply_en = (state_q == ST_PU_SUP) || (state_q == ST_PU_BL) ||
                     (state_q == ST_ON) || (state_q == ST_PD_BL);
  assign bl_en     = (state_q == ST_ON);
  assign on        = on_q;
  assign busy      = phase[0];

  AST_BL_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    bl_en |-> supply_en); // R2
  AST_ON_WITH_BL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_q) |-> bl_en); // R2
  AST_ON_CLEARS_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(on_q) |-> !supply_en && !bl_en); // R3
  AST_CYCLE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_en) |-> $past(cyc_q) == '0); // R5
  AST_ABORT_NO_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PU_BL && !req) |=> !on_q && !bl_en); // R8
endmodule

// File: rtl/pps_sequencer.sv
module pps_sequencer #(
  parameter int DLY_W = 13,
  parameter int DIV_W = 16,
  parameter int CYC_W = 5,
  parameter int CYC_UNIT = 1000,
  parameter logic [15:0] UNLOCK_KEY = 16'hA5C3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        warm_rst,
  output logic        panel_supply_en,
  output logic        backlight_en,
  output logic        stat_on,
  output logic        stat_busy,
  output logic [1:0]  stat_phase
);
  logic             req, tick;
  logic [DLY_W-1:0] pu_dly, bon_dly, pd_dly, boff_dly;
  logic [DIV_W-1:0] divider;
  logic [CYC_W-1:0] cyc_field;

  pps_regs #(.DLY_W(DLY_W), .DIV_W(DIV_W), .CYC_W(CYC_W), .UNLOCK_KEY(UNLOCK_KEY)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .warm_rst(warm_rst), .req(req), .pu_dly(pu_dly), .bon_dly(bon_dly),
    .pd_dly(pd_dly), .boff_dly(boff_dly), .divider(divider), .cyc_field(cyc_field));

  pps_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .divider(divider), .tick(tick));

  pps_fsm #(.DLY_W(DLY_W), .CYC_W(CYC_W), .CYC_UNIT(CYC_UNIT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req(req), .pu_dly(pu_dly),
    .bon_dly(bon_dly), .pd_dly(pd_dly), .boff_dly(boff_dly), .cyc_field(cyc_field),
    .supply_en(panel_supply_en), .bl_en(backlight_en), .on(stat_on),
    .busy(stat_busy), .phase(stat_phase));

  AST_BUSY_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_busy == (stat_phase == 2'd1 || stat_phase == 2'd3)); // R10
endmodule

// File: tb/sim_pps_sequencer.sv
module sim_pps_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        warm_rst = 1'b0;
  logic        panel_supply_en, backlight_en, stat_on, stat_busy;
  logic [1:0]  stat_phase;
  int          errors = 0;
  int          checks = 0;
  localparam logic [15:0] KEY = 16'hA5C3;

  always #2 clk = ~clk;

  pps_sequencer u0 (.*);

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // sel: 0 supply, 1 backlight, 2 stat_on; counts negedges until sel == val
  task automatic wait_sig(input int sel, input logic val, input int maxc, output int n);
    logic s;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      s = (sel == 0) ? panel_supply_en : (sel == 1) ? backlight_en : stat_on;
      if (s == val || n >= maxc) break;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 supply", panel_supply_en, 0, 0);
    chk("R1 backlight", backlight_en, 0, 0);
    chk("R1 on", stat_on, 0, 0);
    chk("R1 phase", stat_phase, 0, 0);
    chk("R1 busy", stat_busy, 0, 0);
  endtask

  task automatic t_locked_defaults();
    int n;
    wr(2'd1, {3'b0, 13'd30, 3'b0, 13'd20});   // locked: ignored
    wr(2'd3, {11'b0, 5'd1, 16'd3});           // locked: ignored
    wr(2'd0, 32'h0000_0001);
    wait_sig(0, 1'b1, 20, n);
    chk("R6 locked divisor: no cycle wait", n, 1, 5);
    chk("R10 phase up", stat_phase, 1, 1);
    chk("R10 busy up", stat_busy, 1, 1);
    wait_sig(1, 1'b1, 5000, n);
    chk("R7 R6 default power-up + backlight-on", n, 2398, 2405);
    chk("R2 on with backlight", stat_on, 1, 1);
    chk("R10 phase on", stat_phase, 2, 2);
    wr(2'd0, 32'h0000_0000);
    wait_sig(1, 1'b0, 10, n);
    chk("R3 backlight off first", panel_supply_en, 1, 1);
    chk("R10 phase down", stat_phase, 3, 3);
    wait_sig(0, 1'b0, 5000, n);
    chk("R7 default backlight-off", n, 1998, 2004);
    chk("R3 on held after supply down", stat_on, 1, 1);
    wait_sig(2, 1'b0, 1000, n);
    chk("R7 default power-down", n, 348, 354);
    chk("R10 phase off", stat_phase, 0, 0);
  endtask

  task automatic t_program_and_cycle();
    int n;
    wr(2'd0, {KEY, 16'h0000});
    wr(2'd1, {3'b0, 13'd30, 3'b0, 13'd20});
    wr(2'd2, {3'b0, 13'd15, 3'b0, 13'd10});
    wr(2'd3, {11'b0, 5'd1, 16'd3});
    wr(2'd0, {KEY, 16'h0001});
    wait_sig(0, 1'b1, 20, n);
    chk("R2 supply rises", panel_supply_en, 1, 1);
    wait_sig(1, 1'b1, 1000, n);
    chk("R4 R2 unlocked delays, tick=4 cycles", n, 192, 206);
    chk("R2 on set", stat_on, 1, 1);
    wr(2'd0, {KEY, 16'h0000});
    wait_sig(1, 1'b0, 10, n);
    wait_sig(0, 1'b0, 1000, n);
    chk("R3 R4 backlight-off delay", n, 56, 66);
    wait_sig(2, 1'b0, 1000, n);
    chk("R3 R4 power-down delay", n, 36, 46);
    wr(2'd0, {KEY, 16'h0001});
    repeat (100) @(negedge clk);
    chk("R5 supply held off in cycle wait", panel_supply_en, 0, 0);
    chk("R10 phase up in cycle wait", stat_phase, 1, 1);
    wait_sig(0, 1'b1, 8000, n);
    chk("R5 power-cycle minimum", n + 102, 3996, 4016);
    wait_sig(1, 1'b1, 1000, n);
  endtask

  task automatic t_abort();
    int n;
    wr(2'd0, {KEY, 16'h0000});
    wait_sig(2, 1'b0, 2000, n);
    wr(2'd0, {KEY, 16'h0001});
    wait_sig(0, 1'b1, 8000, n);
    repeat (10) @(negedge clk);
    wr(2'd0, {KEY, 16'h0000});
    wait_sig(0, 1'b0, 10, n);
    chk("R8 supply drops on abort", panel_supply_en, 0, 0);
    chk("R8 backlight never on", backlight_en, 0, 0);
    chk("R8 on stays clear", stat_on, 0, 0);
    chk("R8 phase down during power-down delay", stat_phase, 3, 3);
    repeat (50) @(negedge clk);
    chk("R8 phase off after power-down delay", stat_phase, 0, 0);
  endtask

  task automatic t_warm();
    int n;
    wr(2'd0, {KEY, 16'h0001});
    wait_sig(1, 1'b1, 9000, n);
    @(negedge clk); warm_rst = 1'b1; @(negedge clk); warm_rst = 1'b0;
    repeat (50) @(negedge clk);
    chk("R9 warm reset ignored without bit", backlight_en, 1, 1);
    wr(2'd0, {KEY, 16'h0003});
    @(negedge clk); warm_rst = 1'b1; @(negedge clk); warm_rst = 1'b0;
    wait_sig(1, 1'b0, 10, n);
    chk("R9 warm reset forces backlight off", n, 1, 3);
    wait_sig(2, 1'b0, 1000, n);
    chk("R9 warm reset reaches off", stat_on, 0, 0);
  endtask

  initial begin
    t_reset();
    t_locked_defaults();
    t_program_and_cycle();
    t_abort();
    t_warm();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule